// File: doc/BRIEF.md
# ULPI Link-Side Register Access Engine

This block sits on the link side of an 8-bit ULPI bus and runs in the ULPI clock domain. A user-side client asks for a single PHY register read or write with a one-cycle strobe that carries the direction, a 6-bit address and the write data. The engine then runs the bus exchange. It puts the command byte on the bus and waits for NXT to accept it. For a write it sends the data byte and ends the transfer with STP. For a read it hands the bus to the PHY, skips the turnaround cycle and captures the returned byte. The result is reported with a one-cycle `done` pulse, or with an `aborted` pulse if the PHY took the bus before the engine's byte was accepted.

Bus ownership is tracked from DIR. After reset the engine stays off the bus until it first samples DIR low. It drops its output enable in the same cycle that DIR is high. After DIR falls it waits one turnaround cycle before driving again. When it is not sending a command it drives the Idle byte. While the PHY owns the bus and NXT is low, every byte outside a register-read data cycle is taken as a receive-command byte and split into three status fields.

The bidirectional data pins are split into an output byte, an output enable and an input byte, so the tristate pad stays outside this block.

Top module: `ulpi_reg_engine`

## Requirements
- R1: After reset the engine leaves the data bus undriven (`ulpi_data_oe` = 0) and ignores request strobes until a clock edge samples `ulpi_dir` low. From the cycle after that edge it drives the Idle byte 8'h00 whenever it owns the bus and has nothing to send.
- R2: `ulpi_data_oe` is 0 in every cycle in which `ulpi_dir` is high, and also in the first cycle after `ulpi_dir` falls. It returns to 1 in the cycle after that.
- R3: The command byte carries the operation code in bits [7:6] (2'b10 for a register write, 2'b11 for a register read) and the register address in bits [5:0].
- R4: For a write, the data byte is driven in the cycle after NXT accepts the command. The cycle after NXT accepts the data byte has `ulpi_stp` = 1 and the bus at 8'h00 for exactly one cycle. `req_done` pulses in the following cycle.
- R5: For a read, the first DIR-high cycle after the command is accepted is a turnaround and is not sampled. The byte in the second DIR-high cycle appears on `req_rdata` together with a one-cycle `req_done` pulse in the next cycle.
- R6: The request ends with a one-cycle `req_aborted` pulse, no `req_done` and `req_busy` low in the next cycle if DIR is sampled high while the command or write data is still unaccepted, or if DIR drops before the read data cycle. A retry after the bus returns completes normally.
- R7: When the PHY owns the bus (DIR high in this cycle and the previous one) and NXT is low, the byte's bits [1:0], [3:2] and [5:4] appear on `line_state`, `vbus_state` and `rx_event` in the next cycle.
- R8: No status capture happens in a DIR turnaround cycle or in the register-read data cycle.
- R9: Only one request is in flight at a time. A strobe that arrives while `req_busy` is high is dropped and never starts a transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | ULPI clock |
| rst | input | 1 | Synchronous active-high reset |
| ulpi_dir | input | 1 | PHY bus-direction signal |
| ulpi_nxt | input | 1 | PHY throttle / accept signal |
| ulpi_data_in | input | 8 | Sampled data bus |
| ulpi_data_out | output | 8 | Byte the link drives |
| ulpi_data_oe | output | 1 | Link drive enable for the data bus |
| ulpi_stp | output | 1 | Stop signal to the PHY |
| req_valid | input | 1 | One-cycle request strobe |
| req_write | input | 1 | 1 = register write, 0 = register read |
| req_addr | input | 6 | Register address |
| req_wdata | input | 8 | Write data |
| req_rdata | output | 8 | Read data, valid with `req_done` |
| req_done | output | 1 | Request completed |
| req_aborted | output | 1 | Request lost to the PHY |
| req_busy | output | 1 | Request in flight |
| line_state | output | 2 | Last captured line state |
| vbus_state | output | 2 | Last captured encoded VBUS state |
| rx_event | output | 2 | Last captured receive event |

## Verification
Every cycle, the assertions check the bus-release rules: no drive while DIR is high or in the cycle after it falls. They also check that STP lasts one cycle with Idle on the bus, that done and aborted never coincide and only follow a busy cycle, and that read data is only taken after a DIR-high cycle. Only the bench scenarios can show the values themselves. These are the command byte for every address, the write data, the returned read byte, the decoded status fields across all 64 patterns, and the absence of capture in turnaround and read-data cycles. The scenarios also cover the abort-and-retry sequences and the dropping of a strobe during a transfer or before the bus is released.

// File: rtl/ulpi_reg_pkg.sv
package ulpi_reg_pkg;

    localparam int DATA_W  = 8;
    localparam int ADDR_W  = 6;
    localparam int FIELD_W = 2;
    localparam int CODE_W  = DATA_W - ADDR_W;

    typedef enum logic [CODE_W-1:0] {
        OP_IDLE = 2'b00,
        OP_TX   = 2'b01,
        OP_REGW = 2'b10,
        OP_REGR = 2'b11
    } ulpi_op_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_CMD,
        S_WDATA,
        S_WSTP,
        S_RWAIT,
        S_RDATA
    } eng_state_e;

    typedef struct packed {
        logic                write;
        logic [ADDR_W-1:0]   addr;
        logic [DATA_W-1:0]   wdata;
    } reg_req_t;

    typedef struct packed {
        logic [FIELD_W-1:0] rx_event;
        logic [FIELD_W-1:0] vbus;
        logic [FIELD_W-1:0] line;
    } rx_status_t;

    function automatic logic [DATA_W-1:0] reg_cmd_byte(input logic write,
                                                       input logic [ADDR_W-1:0] addr);
        ulpi_op_e op;
        op = write ? OP_REGW : OP_REGR;
        return {op, addr};
    endfunction

    function automatic rx_status_t split_status(input logic [3*FIELD_W-1:0] b);
        return rx_status_t'(b);
    endfunction

endpackage

// File: rtl/ulpi_bus_owner.sv
module ulpi_bus_owner (
    input  logic clk,
    input  logic rst,
    input  logic dir,
    output logic dir_q,
    output logic bus_up,
    output logic link_owns
);
    // dir_q: DIR in the previous cycle; a difference marks a turnaround.
    always_ff @(posedge clk) begin
        if (rst) begin
            dir_q  <= 1'b0;
            bus_up <= 1'b0;
        end else begin
            dir_q <= dir;
            if (!dir)
                bus_up <= 1'b1;
        end
    end

    // Drive only after release, never while DIR is high, never in turnaround.
    assign link_owns = bus_up && !dir && !dir_q;

    a_r1_released_after_low: assert property (@(posedge clk) disable iff (rst)
        $rose(bus_up) |-> $past(!dir));

endmodule

// File: rtl/ulpi_rxcmd_capture.sv
module ulpi_rxcmd_capture
    import ulpi_reg_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     dir,
    input  logic                     dir_q,
    input  logic                     nxt,
    input  logic                     in_read_data,
    input  logic [3*FIELD_W-1:0]     data_lo,
    output rx_status_t               status
);
    logic take;
    assign take = dir && dir_q && !nxt && !in_read_data;

    always_ff @(posedge clk) begin
        if (rst)
            status <= '0;
        else if (take)
            status <= split_status(data_lo);
    end

    a_r8_hold_in_turnaround: assert property (@(posedge clk) disable iff (rst)
        (dir != dir_q) |=> $stable(status));

endmodule

// File: rtl/ulpi_reg_fsm.sv
module ulpi_reg_fsm
    import ulpi_reg_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               bus_up,
    input  logic               link_owns,
    input  logic               dir,
    input  logic               nxt,
    input  logic [DATA_W-1:0]  data_in,
    input  logic               req_valid,
    input  reg_req_t           req,
    output logic [DATA_W-1:0]  data_out,
    output logic               stp,
    output logic [DATA_W-1:0]  rdata,
    output logic               done,
    output logic               aborted,
    output logic               busy,
    output logic               in_read_data
);
    eng_state_e state;
    reg_req_t   req_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= S_IDLE;
            req_q   <= '0;
            rdata   <= '0;
            done    <= 1'b0;
            aborted <= 1'b0;
        end else begin
            done    <= 1'b0;
            aborted <= 1'b0;
            unique case (state)
                S_IDLE: begin
                    if (req_valid && bus_up) begin
                        req_q <= req;
                        state <= S_CMD;
                    end
                end
                S_CMD: begin
                    if (dir) begin
                        aborted <= 1'b1;
                        state   <= S_IDLE;
                    end else if (nxt && link_owns) begin
                        state <= req_q.write ? S_WDATA : S_RWAIT;
                    end
                end
                S_WDATA: begin
                    if (dir) begin
                        aborted <= 1'b1;
                        state   <= S_IDLE;
                    end else if (nxt && link_owns) begin
                        state <= S_WSTP;
                    end
                end
                S_WSTP: begin
                    done  <= 1'b1;
                    state <= S_IDLE;
                end
                S_RWAIT: begin
                    if (dir)
                        state <= S_RDATA;
                end
                S_RDATA: begin
                    if (dir && !nxt) begin
                        rdata <= data_in;
                        done  <= 1'b1;
                    end else begin
                        aborted <= 1'b1;
                    end
                    state <= S_IDLE;
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    always_comb begin
        unique case (state)
            S_CMD:   data_out = reg_cmd_byte(req_q.write, req_q.addr);
            S_WDATA: data_out = req_q.wdata;
            default: data_out = {OP_IDLE, {ADDR_W{1'b0}}};
        endcase
    end

    assign stp          = (state == S_WSTP);
    assign busy         = (state != S_IDLE);
    assign in_read_data = (state == S_RDATA);

    a_r5_data_after_turnaround: assert property (@(posedge clk) disable iff (rst)
        (state == S_RDATA) |-> $past(dir));

    a_r9_no_restart: assert property (@(posedge clk) disable iff (rst)
        (state != S_IDLE && state != S_WSTP && state != S_RDATA && !dir && !(nxt && link_owns))
        |=> $stable(req_q));

endmodule

// File: rtl/ulpi_reg_engine.sv
module ulpi_reg_engine
    import ulpi_reg_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 ulpi_dir,
    input  logic                 ulpi_nxt,
    input  logic [DATA_W-1:0]    ulpi_data_in,
    output logic [DATA_W-1:0]    ulpi_data_out,
    output logic                 ulpi_data_oe,
    output logic                 ulpi_stp,
    input  logic                 req_valid,
    input  logic                 req_write,
    input  logic [ADDR_W-1:0]    req_addr,
    input  logic [DATA_W-1:0]    req_wdata,
    output logic [DATA_W-1:0]    req_rdata,
    output logic                 req_done,
    output logic                 req_aborted,
    output logic                 req_busy,
    output logic [FIELD_W-1:0]   line_state,
    output logic [FIELD_W-1:0]   vbus_state,
    output logic [FIELD_W-1:0]   rx_event
);
    logic       dir_q;
    logic       bus_up;
    logic       link_owns;
    logic       in_read_data;
    reg_req_t   req;
    rx_status_t status;

    assign req = '{write: req_write, addr: req_addr, wdata: req_wdata};

    ulpi_bus_owner u_owner (
        .clk       (clk),
        .rst       (rst),
        .dir       (ulpi_dir),
        .dir_q     (dir_q),
        .bus_up    (bus_up),
        .link_owns (link_owns)
    );

    ulpi_reg_fsm u_fsm (
        .clk          (clk),
        .rst          (rst),
        .bus_up       (bus_up),
        .link_owns    (link_owns),
        .dir          (ulpi_dir),
        .nxt          (ulpi_nxt),
        .data_in      (ulpi_data_in),
        .req_valid    (req_valid),
        .req          (req),
        .data_out     (ulpi_data_out),
        .stp          (ulpi_stp),
        .rdata        (req_rdata),
        .done         (req_done),
        .aborted      (req_aborted),
        .busy         (req_busy),
        .in_read_data (in_read_data)
    );

    ulpi_rxcmd_capture u_rxcmd (
        .clk          (clk),
        .rst          (rst),
        .dir          (ulpi_dir),
        .dir_q        (dir_q),
        .nxt          (ulpi_nxt),
        .in_read_data (in_read_data),
        .data_lo      (ulpi_data_in[3*FIELD_W-1:0]),
        .status       (status)
    );

    assign ulpi_data_oe = link_owns;
    assign line_state   = status.line;
    assign vbus_state   = status.vbus;
    assign rx_event     = status.rx_event;

    a_r2_release_on_dir: assert property (@(posedge clk) disable iff (rst)
        ulpi_dir |-> !ulpi_data_oe);

    a_r2_turnaround_quiet: assert property (@(posedge clk) disable iff (rst)
        (!ulpi_dir && $past(ulpi_dir)) |-> !ulpi_data_oe);

    a_r4_stp_one_cycle: assert property (@(posedge clk) disable iff (rst)
        ulpi_stp |=> !ulpi_stp);

    a_r4_stp_with_idle: assert property (@(posedge clk) disable iff (rst)
        ulpi_stp |-> (ulpi_data_out == '0));

    a_r6_single_outcome: assert property (@(posedge clk) disable iff (rst)
        !(req_done && req_aborted));

    a_r9_outcome_follows_busy: assert property (@(posedge clk) disable iff (rst)
        (req_done || req_aborted) |-> $past(req_busy));

endmodule

// File: tb/ulpi_reg_engine_tb.sv
module ulpi_reg_engine_tb;

    logic       clk = 1'b0;
    logic       rst;
    logic       dir, nxt;
    logic [7:0] din;
    logic [7:0] dout;
    logic       oe, stp;
    logic       req_valid, req_write;
    logic [5:0] req_addr;
    logic [7:0] req_wdata, req_rdata;
    logic       req_done, req_aborted, req_busy;
    logic [1:0] line_state, vbus_state, rx_event;

    int n_chk  = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    ulpi_reg_engine u_dut (
        .clk(clk), .rst(rst),
        .ulpi_dir(dir), .ulpi_nxt(nxt), .ulpi_data_in(din),
        .ulpi_data_out(dout), .ulpi_data_oe(oe), .ulpi_stp(stp),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
        .req_wdata(req_wdata), .req_rdata(req_rdata), .req_done(req_done),
        .req_aborted(req_aborted), .req_busy(req_busy),
        .line_state(line_state), .vbus_state(vbus_state), .rx_event(rx_event)
    );

    task automatic tick;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic chk_status(input string tag, input logic [5:0] f);
        chk({tag, " line"}, line_state, f[1:0]);
        chk({tag, " vbus"}, vbus_state, f[3:2]);
        chk({tag, " event"}, rx_event, f[5:4]);
    endtask

    // abort_at: 0 none, 1 during command, 2 during data; probe: stray strobe mid-transfer
    task automatic do_write(input logic [5:0] a, input logic [7:0] d,
                            input int abort_at, input bit probe);
        req_valid = 1; req_write = 1; req_addr = a; req_wdata = d;
        tick;
        req_valid = 0;
        chk("R3 write command byte", dout, {2'b10, a});
        chk("R2 drive during command", oe, 1);
        if (abort_at == 1) begin
            dir = 1; din = 8'hFF; #1;
            chk("R2 release same cycle", oe, 0);
            tick;
            chk("R6 aborted on command", req_aborted, 1);
            chk("R6 no done on abort", req_done, 0);
            chk("R6 not busy after abort", req_busy, 0);
            dir = 0; tick; tick;
            return;
        end
        nxt = 1;
        tick;
        chk("R4 write data byte", dout, d);
        chk("R4 drive data", oe, 1);
        if (abort_at == 2) begin
            nxt = 0; dir = 1; din = 8'hFF; #1;
            chk("R2 release in data", oe, 0);
            tick;
            chk("R6 aborted on data", req_aborted, 1);
            chk("R6 no stp after abort", stp, 0);
            dir = 0; tick; tick;
            return;
        end
        if (probe) begin
            req_valid = 1; req_write = 0; req_addr = ~a;
        end
        tick;
        nxt = 0; req_valid = 0;
        chk("R4 stp pulse", stp, 1);
        chk("R4 idle with stp", dout, 0);
        chk("R4 no done yet", req_done, 0);
        tick;
        chk("R4 done after stp", req_done, 1);
        chk("R4 stp single", stp, 0);
        chk("R9 idle after write", req_busy, 0);
        if (probe) begin
            tick;
            chk("R9 stray strobe dropped busy", req_busy, 0);
            chk("R9 stray strobe no command", dout, 0);
        end
    endtask

    task automatic do_read(input logic [5:0] a, input logic [7:0] v, input bit abort);
        req_valid = 1; req_write = 0; req_addr = a;
        tick;
        req_valid = 0;
        chk("R3 read command byte", dout, {2'b11, a});
        nxt = 1;
        tick;
        nxt = 0; dir = 1; din = ~v; #1;
        chk("R2 release at read turnaround", oe, 0);
        tick;
        if (abort) begin
            dir = 0; din = 8'hC3;
            tick;
            chk("R6 read aborted", req_aborted, 1);
            chk("R6 read no done", req_done, 0);
            tick;
            return;
        end
        din = v;
        tick;
        chk("R5 read done", req_done, 1);
        chk("R5 read data", req_rdata, v);
        dir = 0; din = 8'h96; #1;
        chk("R2 quiet after dir falls", oe, 0);
        tick;
        chk("R2 drive resumes", oe, 1);
        chk("R1 idle byte", dout, 0);
    endtask

    initial begin
        rst = 1; dir = 1; nxt = 0; din = 8'h00;
        req_valid = 0; req_write = 0; req_addr = '0; req_wdata = '0;
        repeat (3) tick;
        rst = 0;
        tick;
        chk("R1 no drive while dir high", oe, 0);
        chk("R1 not busy", req_busy, 0);
        chk("R1 no done", req_done, 0);
        chk_status("R7 reset status", 6'd0);
        req_valid = 1; req_write = 1; req_addr = 6'h11;
        tick;
        req_valid = 0;
        chk("R1 strobe ignored before release", req_busy, 0);
        dir = 0; #1;
        chk("R1 turnaround at release", oe, 0);
        tick;
        chk("R1 drive after release", oe, 1);
        chk("R1 idle byte after release", dout, 0);
        chk("R1 early strobe left no request", req_busy, 0);

        // Status capture sweep
        dir = 1; din = 8'hFF;
        tick;
        chk_status("R8 turnaround not captured", 6'd0);
        for (int b = 0; b < 64; b++) begin
            din = {b[1:0], b[5:0]};
            tick;
            chk_status("R7 status fields", b[5:0]);
        end
        dir = 0; din = 8'h00;
        tick; tick;

        // Writes over every address
        for (int a = 0; a < 64; a++)
            do_write(a[5:0], 8'((a * 37 + 11) & 8'hFF), 0, a == 5);

        // Reads over every address; status must hold
        for (int a = 0; a < 64; a++) begin
            do_read(a[5:0], 8'((a * 7 + 3) & 8'hFF), 1'b0);
            chk_status("R8 read data not captured", 6'h3F);
        end

        // Aborts and retries
        do_write(6'h2A, 8'h5C, 1, 1'b0);
        do_write(6'h2A, 8'h5C, 0, 1'b0);
        do_write(6'h0F, 8'hE1, 2, 1'b0);
        do_write(6'h0F, 8'hE1, 0, 1'b0);
        do_read(6'h33, 8'h81, 1'b1);
        do_read(6'h33, 8'h81, 1'b0);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule